// File: doc/BRIEF.md
# Superpage Promotion Decision Unit

This unit watches the stream of base-page TLB misses and decides when an aligned group of sixteen contiguous virtual pages (8 KB each, 128 KB in total) should be turned into a single superpage TLB entry. Every miss is charged to the group that holds the missing page. A small table keeps the recently active groups, each with a running miss count. The unit follows a rent-or-buy rule. It keeps paying the per-miss cost until the misses in a group equal the copy cost `N`, which is given in miss units. At that point it asks for promotion. Total cost then stays within twice the cost of the best choice made in hindsight.

A promotion request carries the base virtual page of the aligned group. It stays on the output until the OS or copy engine acknowledges it. One more request can wait behind it. A request that finds both places taken is discarded and counted. A group that has been promoted is marked, so later misses inside it neither count nor raise a second request. The copy itself, the page tables and the TLB are outside this unit.

Top module: `spp_promoter`

## Requirements
- R1: After reset, `promo_valid` is 0 and `drop_count` is 0.
- R2: A miss on page `vpn` is charged to group `vpn >> 4`, so all sixteen pages of an aligned group share one counter. A request reports `promo_base = group << 4`, and its low four bits are always zero.
- R3: A miss that brings its group's count up to `cost_n` raises a request. The request is visible in the cycle after that miss is sampled, and no earlier miss raises one. A `cost_n` of 0 acts as 1.
- R4: While `promo_ack` is low, an asserted request stays asserted with an unchanged `promo_base`.
- R5: Once a group has been promoted, further misses in it change nothing: no new request appears.
- R6: A request raised while another is shown waits in a one-deep queue. It appears in the cycle after the shown request is acknowledged.
- R7: A request raised while both the output and the queue are occupied is discarded, and `drop_count` increases by exactly one.
- R8: An acknowledge and a new request in the same cycle cause no drop. The new request goes to whichever place the acknowledge frees.
- R9: The table tracks 8 groups and replaces the least recently missed one. A group that is evicted and later missed again starts counting from one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A base-page TLB miss is presented this cycle |
| miss_vpn | input | VPN_W (20) | Virtual page number of the miss |
| cost_n | input | CNT_W (8) | Copy cost in miss units; the promotion threshold |
| promo_ack | input | 1 | Consumer accepts the shown request |
| promo_valid | output | 1 | A promotion request is shown |
| promo_base | output | VPN_W (20) | First virtual page of the group to promote |
| drop_count | output | DROP_W (8) | Number of discarded requests, saturating |

## Verification
Two functions can land on the same edge. The consumer can acknowledge the shown request, and the miss path can fire a new promotion, in the same cycle. The bench forces this coincidence twice with a threshold of one. The first time the queue is empty and the new request must go straight to the output. The second time the queue is full, so the queued entry must move forward and the new one must take its place. In both cases the bench reads the order of the following requests and checks that `drop_count` stays at zero.

// File: rtl/spp_pkg.sv
package spp_pkg;
    // Where a newly raised promotion request is placed
    typedef enum logic [1:0] {
        PUT_NONE = 2'd0,
        PUT_OUT  = 2'd1,
        PUT_WAIT = 2'd2,
        PUT_LOST = 2'd3
    } put_e;
endpackage

// File: rtl/spp_region_table.sv
// Tracks recently missed aligned groups and fires once per group at threshold.
module spp_region_table #(
    parameter int VPN_W    = 20,
    parameter int GRP_BITS = 4,
    parameter int ENTRIES  = 8,   // power of two
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_valid,
    input  logic [VPN_W-1:0] miss_vpn,
    input  logic [CNT_W-1:0] cost_n,
    output logic             fire,
    output logic [VPN_W-1:0] fire_base
);
    localparam int RID_W = VPN_W - GRP_BITS;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic             valid;
        logic             done;
        logic [RID_W-1:0] rid;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] age;
    } ent_t;

    ent_t [ENTRIES-1:0] tab_d, tab_q;

    logic [RID_W-1:0] rid;
    logic [CNT_W-1:0] thr;
    logic [CNT_W-1:0] next_cnt;
    logic             hit;
    logic [IDX_W-1:0] hit_idx, vic_idx, sel, sel_age;

    assign rid       = miss_vpn[VPN_W-1:GRP_BITS];
    assign thr       = (cost_n == '0) ? CNT_W'(1) : cost_n;
    assign fire_base = {rid, {GRP_BITS{1'b0}}};

    // Lookup: matching entry, and the oldest entry as victim
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        vic_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (tab_q[i].valid && tab_q[i].rid == rid) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (tab_q[i].age == OLDEST) begin
                vic_idx = IDX_W'(i);
            end
        end
        sel      = hit ? hit_idx : vic_idx;
        sel_age  = tab_q[sel].age;
        next_cnt = tab_q[sel].cnt + CNT_W'(1);
    end

    // Next-state computation
    always_comb begin
        tab_d = tab_q;
        fire  = 1'b0;
        if (miss_valid) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == sel) begin
                    tab_d[i].age = '0;
                end else if (tab_q[i].age < sel_age) begin
                    tab_d[i].age = tab_q[i].age + IDX_W'(1);
                end
            end
            if (hit) begin
                if (!tab_q[sel].done) begin
                    tab_d[sel].cnt = next_cnt;
                    if (next_cnt >= thr) begin
                        tab_d[sel].done = 1'b1;
                        fire            = 1'b1;
                    end
                end
            end else begin
                tab_d[sel].valid = 1'b1;
                tab_d[sel].rid   = rid;
                tab_d[sel].cnt   = CNT_W'(1);
                tab_d[sel].done  = (thr == CNT_W'(1));
                fire             = (thr == CNT_W'(1));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tab_q[i] <= '{valid: 1'b0, done: 1'b0, rid: '0, cnt: '0,
                              age: IDX_W'(i)};
            end
        end else begin
            tab_q <= tab_d;
        end
    end
endmodule

// File: rtl/spp_req_slot.sv
// Output register plus one waiting slot; overflow is counted.
module spp_req_slot
    import spp_pkg::*;
#(
    parameter int VPN_W  = 20,
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [VPN_W-1:0]  push_base,
    input  logic              ack,
    output logic              out_valid,
    output logic [VPN_W-1:0]  out_base,
    output logic [DROP_W-1:0] drops
);
    typedef struct packed {
        logic              out_v;
        logic [VPN_W-1:0]  out_b;
        logic              wait_v;
        logic [VPN_W-1:0]  wait_b;
        logic [DROP_W-1:0] lost;
    } slot_t;

    slot_t st_d, st_q;
    slot_t after_ack;
    put_e  put;

    always_comb begin
        after_ack = st_q;
        if (st_q.out_v && ack) begin
            after_ack.out_v = 1'b0;
        end
        if (!after_ack.out_v && after_ack.wait_v) begin
            after_ack.out_v  = 1'b1;
            after_ack.out_b  = after_ack.wait_b;
            after_ack.wait_v = 1'b0;
        end

        if (!push)                    put = PUT_NONE;
        else if (!after_ack.out_v)    put = PUT_OUT;
        else if (!after_ack.wait_v)   put = PUT_WAIT;
        else                          put = PUT_LOST;

        st_d = after_ack;
        case (put)
            PUT_OUT: begin
                st_d.out_v = 1'b1;
                st_d.out_b = push_base;
            end
            PUT_WAIT: begin
                st_d.wait_v = 1'b1;
                st_d.wait_b = push_base;
            end
            PUT_LOST: begin
                if (after_ack.lost != '1) begin
                    st_d.lost = after_ack.lost + DROP_W'(1);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_v;
    assign out_base  = st_q.out_b;
    assign drops     = st_q.lost;
endmodule

// File: rtl/spp_promoter.sv
module spp_promoter #(
    parameter int VPN_W    = 20,
    parameter int GRP_BITS = 4,
    parameter int ENTRIES  = 8,
    parameter int CNT_W    = 8,
    parameter int DROP_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [VPN_W-1:0]  miss_vpn,
    input  logic [CNT_W-1:0]  cost_n,
    input  logic              promo_ack,
    output logic              promo_valid,
    output logic [VPN_W-1:0]  promo_base,
    output logic [DROP_W-1:0] drop_count
);
    logic             fire;
    logic [VPN_W-1:0] fire_base;

    spp_region_table #(
        .VPN_W(VPN_W), .GRP_BITS(GRP_BITS), .ENTRIES(ENTRIES), .CNT_W(CNT_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_vpn(miss_vpn),
        .cost_n(cost_n), .fire(fire), .fire_base(fire_base)
    );

    spp_req_slot #(
        .VPN_W(VPN_W), .DROP_W(DROP_W)
    ) u_slot (
        .clk(clk), .rst_n(rst_n), .push(fire), .push_base(fire_base),
        .ack(promo_ack), .out_valid(promo_valid), .out_base(promo_base),
        .drops(drop_count)
    );
endmodule

// File: rtl/spp_promoter_chk.sv
module spp_promoter_chk #(
    parameter int VPN_W    = 20,
    parameter int GRP_BITS = 4,
    parameter int DROP_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              promo_ack,
    input logic              promo_valid,
    input logic [VPN_W-1:0]  promo_base,
    input logic [DROP_W-1:0] drop_count
);
    // R4: a shown request is held until acknowledged
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (promo_valid && !promo_ack) |=> (promo_valid && $stable(promo_base)));

    // R2: the reported base is group aligned
    p_base_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        promo_valid |-> (promo_base[GRP_BITS-1:0] == '0));

    // R7: the discard count moves by at most one per cycle
    p_drop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (drop_count == $past(drop_count) ||
                  drop_count == $past(drop_count) + DROP_W'(1)));

    // R6: with nothing shown there is room, so nothing is discarded
    p_no_drop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !promo_valid |=> $stable(drop_count));
endmodule

bind spp_promoter spp_promoter_chk #(
    .VPN_W(VPN_W), .GRP_BITS(GRP_BITS), .DROP_W(DROP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .promo_ack(promo_ack), .promo_valid(promo_valid),
    .promo_base(promo_base), .drop_count(drop_count)
);

// File: tb/sim_spp_promoter.sv
module sim_spp_promoter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic [19:0] miss_vpn = '0;
    logic [7:0]  cost_n = 8'd4;
    logic        promo_ack = 1'b0;
    logic        promo_valid;
    logic [19:0] promo_base;
    logic [7:0]  drop_count;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    spp_promoter u0 (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_vpn(miss_vpn),
        .cost_n(cost_n), .promo_ack(promo_ack), .promo_valid(promo_valid),
        .promo_base(promo_base), .drop_count(drop_count)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_req(input string req, input bit v, input logic [19:0] base);
        chk(promo_valid == v, req, promo_valid, v);
        if (v) chk(promo_base == base, req, promo_base, base);
    endtask

    task automatic do_reset(input logic [7:0] n);
        @(negedge clk);
        rst_n = 1'b0; miss_valid = 1'b0; promo_ack = 1'b0; cost_n = n;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One cycle with optional miss and optional acknowledge
    task automatic cyc(input bit m, input logic [19:0] vpn, input bit a);
        miss_valid = m; miss_vpn = vpn; promo_ack = a;
        @(negedge clk);
        miss_valid = 1'b0; promo_ack = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(8'd4);
        chk(promo_valid == 1'b0, "R1", promo_valid, 0);
        chk(drop_count == 8'd0, "R1", drop_count, 0);
    endtask

    task automatic t_threshold();
        do_reset(8'd4);
        cyc(1, 20'd64, 0); chk_req("R3", 0, 0);
        cyc(1, 20'd65, 0); chk_req("R3", 0, 0);
        cyc(1, 20'd70, 0); chk_req("R2", 0, 0);
        cyc(1, 20'd79, 0); chk_req("R3", 1, 20'd64);
        for (int k = 0; k < 5; k++) cyc(0, 0, 0);
        chk_req("R4", 1, 20'd64);
        cyc(0, 0, 1); chk_req("R4", 0, 0);
        for (int k = 0; k < 6; k++) cyc(1, 20'd66, 0);
        chk_req("R5", 0, 0);
        chk(drop_count == 8'd0, "R5", drop_count, 0);
    endtask

    task automatic t_zero_cost();
        do_reset(8'd0);
        cyc(1, 20'h333, 0); chk_req("R3", 1, 20'h330);
    endtask

    task automatic t_overflow();
        do_reset(8'd1);
        cyc(1, 20'h100, 0);
        cyc(1, 20'h110, 0);
        chk(drop_count == 8'd0, "R6", drop_count, 0);
        cyc(1, 20'h120, 0);
        chk_req("R6", 1, 20'h100);
        chk(drop_count == 8'd1, "R7", drop_count, 1);
        cyc(0, 0, 1); chk_req("R6", 1, 20'h110);
        cyc(0, 0, 1); chk_req("R7", 0, 0);
        chk(drop_count == 8'd1, "R7", drop_count, 1);
    endtask

    task automatic t_coincide();
        do_reset(8'd1);
        cyc(1, 20'h20, 0); chk_req("R8", 1, 20'h20);
        cyc(1, 20'h35, 1); chk_req("R8", 1, 20'h30);
        cyc(1, 20'h40, 0); chk_req("R8", 1, 20'h30);
        cyc(1, 20'h50, 1); chk_req("R8", 1, 20'h40);
        chk(drop_count == 8'd0, "R8", drop_count, 0);
        cyc(0, 0, 1); chk_req("R8", 1, 20'h50);
        cyc(0, 0, 1); chk_req("R8", 0, 0);
        chk(drop_count == 8'd0, "R8", drop_count, 0);
    endtask

    task automatic t_lru();
        do_reset(8'd3);
        for (int g = 0; g < 8; g++) cyc(1, 20'(g * 16), 0);
        cyc(1, 20'd0, 0);             // group 0 now at two misses
        cyc(1, 20'd128, 0);           // ninth group evicts group 1
        chk_req("R9", 0, 0);
        cyc(1, 20'd5, 0); chk_req("R9", 1, 20'd0);
        cyc(0, 0, 1);
        cyc(1, 20'd16, 0);
        cyc(1, 20'd17, 0); chk_req("R9", 0, 0);
        cyc(1, 20'd18, 0); chk_req("R9", 1, 20'd16);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_threshold();
        t_zero_cost();
        t_overflow();
        t_coincide();
        t_lru();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule